// File: doc/BRIEF.md
# Bakery-Lock Shared Counter Master

This block is a bus master that increments a counter held in shared memory. It uses a mutual-exclusion lock with numbered tickets so that several agents can share the counter. Every memory access is a plain single-word read or write. No locked or exclusive transfer is ever issued, because the algorithm is correct as long as each single read and each single write is atomic.

Each agent owns one slot in an array of "entering" flags and one slot in an array of ticket numbers. The block is given:

- its own slot index;
- the number of agents N;
- the base addresses of both arrays and of the counter;
- how many increments to perform.

A `start` pulse launches the run. The block then repeats a fixed sequence once per loop: take a ticket, wait its turn, do the read-modify-write of the counter, and release. It raises `done` when all loops are complete.

The memory side is a request/acknowledge port with one transfer in flight at a time. Slot k of an array sits at `base + 4*k`. A flag value of 1 means set and 0 means clear. A ticket of 0 means the agent holds no ticket.

Top module: `bakery_master`

## Requirements
- R1: After reset, `mem_req` and `done` are low and `loops_done` is zero.
- R2: Each loop issues exactly five writes, in this order:
  1. entering flag of its own slot = 1;
  2. ticket of its own slot = chosen ticket;
  3. entering flag of its own slot = 0;
  4. counter = value read + 1;
  5. ticket of its own slot = 0.
- R3: Before writing its ticket, the block reads all N ticket slots in index order 0..N-1. Its ticket is the largest value read plus one.
- R4: For each other agent, the block re-reads that agent's entering flag for as long as it is nonzero. It does not touch the counter while waiting.
- R5: For each other agent, the block re-reads that agent's ticket while it is nonzero and the pair (ticket, index) precedes its own. Pair A precedes pair B when A's ticket is smaller, or when the tickets are equal and A's index is lower.
- R6: When another agent holds an equal ticket but a higher index, the block does not wait on it and goes on to the counter.
- R7: The counter is read and then written with that value plus one, only while the lock is held. After a run the counter has grown by exactly the loop count.
- R8: `loops_done` counts completed loops. `done` goes high when it equals the configured count. While `done` is high the block issues no request.
- R9: A loop that meets no contention performs exactly 3N-1 reads: N ticket reads, N-1 flag reads, N-1 ticket checks and one counter read.
- R10: At most one transfer is outstanding. A request holds its address, data and direction unchanged until acknowledged.
- R11: A loop count of zero gives `done` with no memory traffic. Configuration is sampled only on `start`, so changing it while idle or done causes no traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run; configuration is sampled here |
| agent_idx | input | AGW | Own slot index |
| agent_count | input | AGW+1 | Number of agents N (at least 1) |
| flag_base | input | AW | Base byte address of the entering-flag array |
| num_base | input | AW | Base byte address of the ticket array |
| ctr_base | input | AW | Byte address of the shared counter |
| loop_limit | input | LW | Number of increments to perform |
| done | output | 1 | Run finished |
| loops_done | output | LW | Completed loops in the current run |
| mem_req | output | 1 | Request valid, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Acknowledge; completes the outstanding request |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The bench stands in for the other agents by changing their flag and ticket slots while the block is running. It then checks that the block stalls where it must and resumes once the obstruction is gone.

The tie case is the sharpest test. If the index tie-break is reversed, the block either enters while a lower-indexed holder of an equal ticket is present, or deadlocks against a higher-indexed one. A ticket taken from anything but the true maximum shows up in the logged ticket write. A design that skipped the flag wait, or ignored a smaller ticket, would write the counter while it is supposed to be blocked.

Exact write sequences and exact read totals on uncontended loops expose a lost or extra access. A zero loop count, and configuration changes made without `start`, must leave the memory port silent.

// File: rtl/bakery_pkg.sv
package bakery_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SET_ENTER,
    ST_SCAN,
    ST_WR_TICKET,
    ST_CLR_ENTER,
    ST_POLL_FLAG,
    ST_POLL_NUM,
    ST_RD_CNT,
    ST_WR_CNT,
    ST_CLR_TICKET,
    ST_DONE
  } bk_state_e;

  // Pair (na, ia) comes strictly before (nb, ib) in lock order.
  function automatic logic precedes(input logic [31:0] na, input logic [31:0] ia,
                                    input logic [31:0] nb, input logic [31:0] ib);
    return (na < nb) || ((na == nb) && (ia < ib));
  endfunction

  // An agent with ticket 'other_num' at index 'other_idx' no longer blocks us.
  function automatic logic may_pass(input logic [31:0] my_num, input logic [31:0] my_idx,
                                    input logic [31:0] other_num, input logic [31:0] other_idx);
    return (other_num == 32'd0) || precedes(my_num, my_idx, other_num, other_idx);
  endfunction

endpackage

// File: rtl/bakery_port.sv
module bakery_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_done,
  output logic [DW-1:0] xfer_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_req   <= 1'b1;
      mem_we    <= issue_we;
      mem_addr  <= issue_addr;
      mem_wdata <= issue_wdata;
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  assign xfer_done  = mem_req && mem_ack;
  assign xfer_rdata = mem_rdata;

endmodule

// File: rtl/bakery_maxreg.sv
module bakery_maxreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] value,
  output logic [DW-1:0] max_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     max_q <= '0;
    else if (clear)                 max_q <= '0;
    else if (load && value > max_q) max_q <= value;
  end

endmodule

// File: rtl/bakery_ctrl.sv
module bakery_ctrl
  import bakery_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int AGW = 3,
  parameter int LW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AGW-1:0] agent_idx,
  input  logic [AGW:0]  agent_count,
  input  logic [AW-1:0] flag_base,
  input  logic [AW-1:0] num_base,
  input  logic [AW-1:0] ctr_base,
  input  logic [LW-1:0] loop_limit,
  output logic          issue,
  output logic          issue_we,
  output logic [AW-1:0] issue_addr,
  output logic [DW-1:0] issue_wdata,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_rdata,
  output logic          max_clear,
  output logic          max_load,
  input  logic [DW-1:0] max_q,
  output logic          done,
  output logic [LW-1:0] loops_done,
  output logic          cs_held
);

  localparam int IW = AGW + 1;

  bk_state_e     state;
  logic          waiting;
  logic [IW-1:0] idx;
  logic [IW-1:0] me_q;
  logic [IW-1:0] n_q;
  logic [AW-1:0] fb_q, nb_q, cb_q;
  logic [LW-1:0] lim_q;
  logic [DW-1:0] ticket;
  logic [DW-1:0] cnt_val;

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] base, input logic [IW-1:0] i);
    return base + (AW'(i) << 2);
  endfunction

  function automatic logic [DW-1:0] plus_one(input logic [DW-1:0] v);
    return v + DW'(1);
  endfunction

  logic access_st, poll_st, need_skip, last_idx, pass_now;

  assign access_st = (state != ST_IDLE) && (state != ST_DONE);
  assign poll_st   = (state == ST_POLL_FLAG) || (state == ST_POLL_NUM);
  assign need_skip = poll_st && (idx == me_q);
  assign last_idx  = (idx + IW'(1)) == n_q;
  assign pass_now  = may_pass(32'(ticket), 32'(me_q), 32'(xfer_rdata), 32'(idx));

  assign issue     = access_st && !waiting && !need_skip;
  assign max_clear = (state == ST_SET_ENTER) && xfer_done;
  assign max_load  = (state == ST_SCAN) && xfer_done;
  assign done      = (state == ST_DONE);
  assign cs_held   = (state == ST_RD_CNT) || (state == ST_WR_CNT);

  always_comb begin
    issue_we    = 1'b0;
    issue_addr  = cb_q;
    issue_wdata = '0;
    unique case (state)
      ST_SET_ENTER:  begin issue_we = 1'b1; issue_addr = slot(fb_q, me_q); issue_wdata = DW'(1); end
      ST_SCAN:       issue_addr = slot(nb_q, idx);
      ST_WR_TICKET:  begin issue_we = 1'b1; issue_addr = slot(nb_q, me_q); issue_wdata = plus_one(max_q); end
      ST_CLR_ENTER:  begin issue_we = 1'b1; issue_addr = slot(fb_q, me_q); end
      ST_POLL_FLAG:  issue_addr = slot(fb_q, idx);
      ST_POLL_NUM:   issue_addr = slot(nb_q, idx);
      ST_RD_CNT:     issue_addr = cb_q;
      ST_WR_CNT:     begin issue_we = 1'b1; issue_addr = cb_q; issue_wdata = plus_one(cnt_val); end
      ST_CLR_TICKET: begin issue_we = 1'b1; issue_addr = slot(nb_q, me_q); end
      default:       ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      waiting    <= 1'b0;
      idx        <= '0;
      me_q       <= '0;
      n_q        <= '0;
      fb_q       <= '0;
      nb_q       <= '0;
      cb_q       <= '0;
      lim_q      <= '0;
      ticket     <= '0;
      cnt_val    <= '0;
      loops_done <= '0;
    end else begin
      if (issue) waiting <= 1'b1;
      if (state == ST_IDLE || state == ST_DONE) begin
        if (start) begin
          me_q       <= {1'b0, agent_idx};
          n_q        <= agent_count;
          fb_q       <= flag_base;
          nb_q       <= num_base;
          cb_q       <= ctr_base;
          lim_q      <= loop_limit;
          loops_done <= '0;
          state      <= (loop_limit == '0) ? ST_DONE : ST_SET_ENTER;
        end
      end else if (need_skip) begin
        if (last_idx) state <= ST_RD_CNT;
        else begin
          idx   <= idx + IW'(1);
          state <= ST_POLL_FLAG;
        end
      end else if (waiting && xfer_done) begin
        waiting <= 1'b0;
        unique case (state)
          ST_SET_ENTER: begin idx <= '0; state <= ST_SCAN; end
          ST_SCAN: begin
            if (last_idx) state <= ST_WR_TICKET;
            else          idx   <= idx + IW'(1);
          end
          ST_WR_TICKET: begin ticket <= plus_one(max_q); state <= ST_CLR_ENTER; end
          ST_CLR_ENTER: begin idx <= '0; state <= ST_POLL_FLAG; end
          ST_POLL_FLAG: if (xfer_rdata == '0) state <= ST_POLL_NUM;
          ST_POLL_NUM: begin
            if (pass_now) begin
              if (last_idx) state <= ST_RD_CNT;
              else begin
                idx   <= idx + IW'(1);
                state <= ST_POLL_FLAG;
              end
            end
          end
          ST_RD_CNT: begin cnt_val <= xfer_rdata; state <= ST_WR_CNT; end
          ST_WR_CNT: state <= ST_CLR_TICKET;
          ST_CLR_TICKET: begin
            loops_done <= loops_done + LW'(1);
            state      <= ((loops_done + LW'(1)) == lim_q) ? ST_DONE : ST_SET_ENTER;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/bakery_master.sv
module bakery_master #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int AGW = 3,
  parameter int LW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AGW-1:0] agent_idx,
  input  logic [AGW:0]   agent_count,
  input  logic [AW-1:0]  flag_base,
  input  logic [AW-1:0]  num_base,
  input  logic [AW-1:0]  ctr_base,
  input  logic [LW-1:0]  loop_limit,
  output logic           done,
  output logic [LW-1:0]  loops_done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);

  logic          issue, issue_we, xfer_done, max_clear, max_load, cs_held;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata, xfer_rdata, max_q;

  bakery_ctrl #(.AW(AW), .DW(DW), .AGW(AGW), .LW(LW)) u_ctrl (
    .clk, .rst_n, .start, .agent_idx, .agent_count, .flag_base, .num_base,
    .ctr_base, .loop_limit, .issue, .issue_we, .issue_addr, .issue_wdata,
    .xfer_done, .xfer_rdata, .max_clear, .max_load, .max_q, .done,
    .loops_done, .cs_held
  );

  bakery_port #(.AW(AW), .DW(DW)) u_port (
    .clk, .rst_n, .issue, .issue_we, .issue_addr, .issue_wdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .xfer_done, .xfer_rdata
  );

  bakery_maxreg #(.DW(DW)) u_max (
    .clk, .rst_n, .clear(max_clear), .load(max_load), .value(xfer_rdata), .max_q
  );

endmodule

// File: rtl/bakery_master_chk.sv
module bakery_master_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int AGW = 3,
  parameter int LW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AGW-1:0] agent_idx,
  input logic [AW-1:0]  flag_base,
  input logic [AW-1:0]  ctr_base,
  input logic [LW-1:0]  loop_limit,
  input logic           done,
  input logic [LW-1:0]  loops_done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack,
  input logic           cs_held
);

  logic [AW-1:0] own_flag_addr;
  assign own_flag_addr = flag_base + (AW'(agent_idx) << 2);

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r7_counter_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == ctr_base) |-> cs_held);

  a_r2_flag_values: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_addr == own_flag_addr) |-> (mem_wdata <= DW'(1)));

  a_r8_done_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (loops_done == loop_limit));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

endmodule

bind bakery_master bakery_master_chk #(.AW(AW), .DW(DW), .AGW(AGW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .agent_idx(agent_idx), .flag_base(flag_base),
  .ctr_base(ctr_base), .loop_limit(loop_limit), .done(done), .loops_done(loops_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .cs_held(cs_held)
);

// File: tb/bakery_master_bench.sv
module bakery_master_bench;

  localparam int AW = 32, DW = 32, AGW = 3, LW = 16;
  localparam logic [31:0] FB = 32'h100, NB = 32'h200, CB = 32'h300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AGW-1:0] agent_idx = '0;
  logic [AGW:0] agent_count = 4'd1;
  logic [LW-1:0] loop_limit = '0;
  logic done, mem_req, mem_we, mem_ack;
  logic [LW-1:0] loops_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  bakery_master #(.AW(AW), .DW(DW), .AGW(AGW), .LW(LW)) u_bakery_master (
    .clk, .rst_n, .start, .agent_idx, .agent_count, .flag_base(FB), .num_base(NB),
    .ctr_base(CB), .loop_limit, .done, .loops_done, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_ack, .mem_rdata
  );

  // memory model with write log, pokes from the tasks go through here too
  logic [31:0] mem [0:255];
  logic [31:0] wl_a [0:63];
  logic [31:0] wl_d [0:63];
  int wr_n = 0, rd_n = 0;
  logic log_clr = 1'b0, poke_en = 1'b0;
  logic [7:0] poke_a = '0;
  logic [31:0] poke_d = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 32'd0;
  initial mem_ack = 1'b0;
  initial mem_rdata = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (poke_en) mem[poke_a] <= poke_d;
    if (log_clr) begin
      wr_n <= 0;
      rd_n <= 0;
    end else if (mem_req && !mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        if (wr_n < 64) begin
          wl_a[wr_n] <= mem_addr;
          wl_d[wr_n] <= mem_wdata;
        end
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        rd_n <= rd_n + 1;
      end
    end
    if (mem_req && !mem_ack && !log_clr) mem_ack <= 1'b1;
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = addr[9:2]; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic launch(input int me, input int n, input int loops);
    clear_log();
    agent_idx = AGW'(me); agent_count = 4'(n); loop_limit = LW'(loops);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(req, {31'd0, done}, 32'd1);
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 req", {31'd0, mem_req}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 loops", 32'(loops_done), 0);
  endtask

  task automatic t_write_order();
    poke(CB, 32'd41);
    launch(2, 4, 1);
    wait_done("R8 done");
    chk("R2 write count", wr_n, 5);
    chk("R2 w0 addr", wl_a[0], FB + 8); chk("R2 w0 data", wl_d[0], 1);
    chk("R2 w1 addr", wl_a[1], NB + 8); chk("R3 ticket", wl_d[1], 1);
    chk("R2 w2 addr", wl_a[2], FB + 8); chk("R2 w2 data", wl_d[2], 0);
    chk("R7 w3 addr", wl_a[3], CB);     chk("R7 w3 data", wl_d[3], 42);
    chk("R2 w4 addr", wl_a[4], NB + 8); chk("R2 w4 data", wl_d[4], 0);
    chk("R9 reads", rd_n, 11);
    chk("R8 loops", 32'(loops_done), 1);
  endtask

  task automatic t_multi_loop();
    poke(CB, 32'd100);
    launch(0, 1, 5);
    wait_done("R8 done multi");
    chk("R7 counter", mem[CB[9:2]], 105);
    chk("R2 writes", wr_n, 25);
    chk("R9 reads N=1", rd_n, 10);
    chk("R8 loops multi", 32'(loops_done), 5);
  endtask

  task automatic t_max_ticket();
    logic [31:0] c0;
    c0 = mem[CB[9:2]];
    poke(NB + 4, 32'd7);
    poke(NB + 12, 32'd3);
    launch(0, 4, 1);
    idle(200);
    chk("R3 ticket max+1", wl_d[1], 8);
    chk("R5 blocked by smaller ticket", mem[CB[9:2]], c0);
    poke(NB + 12, 32'd0);
    idle(200);
    chk("R5 still blocked", {31'd0, done}, 0);
    poke(NB + 4, 32'd0);
    wait_done("R5 resumes");
    chk("R7 counter +1", mem[CB[9:2]], c0 + 1);
  endtask

  task automatic t_flag_poll();
    logic [31:0] c0;
    c0 = mem[CB[9:2]];
    poke(FB, 32'd1);
    launch(1, 3, 1);
    idle(200);
    chk("R4 blocked on flag", mem[CB[9:2]], c0);
    chk("R4 polling reads", {31'd0, rd_n > 20}, 1);
    poke(FB, 32'd0);
    wait_done("R4 resumes");
    chk("R4 counter +1", mem[CB[9:2]], c0 + 1);
  endtask

  task automatic t_tie_lower_wins();
    logic [31:0] c0;
    c0 = mem[CB[9:2]];
    poke(FB, 32'd1);
    launch(2, 3, 1);
    idle(200);
    poke(NB, 32'd1);
    poke(FB, 32'd0);
    idle(200);
    chk("R5 tie lower index blocks", mem[CB[9:2]], c0);
    poke(NB, 32'd0);
    wait_done("R5 tie resumes");
    chk("R5 tie counter", mem[CB[9:2]], c0 + 1);
  endtask

  task automatic t_tie_higher_loses();
    logic [31:0] c0;
    c0 = mem[CB[9:2]];
    poke(FB + 4, 32'd1);
    launch(0, 3, 1);
    idle(200);
    poke(NB + 4, 32'd1);
    poke(FB + 4, 32'd0);
    wait_done("R6 no wait on higher index");
    chk("R6 counter", mem[CB[9:2]], c0 + 1);
    poke(NB + 4, 32'd0);
  endtask

  task automatic t_zero_loops();
    launch(1, 2, 0);
    idle(3);
    chk("R11 done on zero", {31'd0, done}, 1);
    chk("R11 no writes", wr_n, 0);
    chk("R11 no reads", rd_n, 0);
    loop_limit = LW'(3);
    agent_count = 4'd4;
    idle(30);
    chk("R11 no traffic without start", wr_n + rd_n, 0);
    chk("R11 loops zero", 32'(loops_done), 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_write_order();
    t_multi_loop();
    t_max_ticket();
    t_flag_poll();
    t_tie_lower_wins();
    t_tie_higher_loses();
    t_zero_loops();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule